// File: doc/BRIEF.md
# Serial Output-Enable Control Slave

This block is a write-only slave on a two-wire serial bus (SCL clock line, SDA open-drain data line). It runs entirely from a fast system clock that oversamples both bus lines. From each transaction it takes the bytes it is sent and stores the relevant bits in three small control registers. Those registers drive one enable per differential output pair and one test-mode control bit for a clock distribution stage. A disabled pair is meant to sit in high impedance. The feedback output of that stage has no bit here and so can never be switched off over the bus.

Every write has a fixed block form. A start condition is followed by the 7-bit device address with a write direction bit, then a command byte, then a count byte, then up to "count" data bytes. The command byte selects the first register to write, and the register index advances by one for each data byte. The slave acknowledges a byte by pulling SDA low for the ninth SCL period. A stop condition, or a repeated start, ends the transaction at any point. Registers already written by that transaction keep their new contents.

The control flow is a single state machine. Its states are IDLE, ADDR, ACK_ADDR, CMD, ACK_CMD, CNT, ACK_CNT, DATA, ACK_DATA and SKIP. The transitions are as follows:
- Start goes from any state to ADDR.
- Stop goes from any state to IDLE.
- ADDR goes to ACK_ADDR on a matching write address, or to SKIP on any other address byte.
- ACK_ADDR goes to CMD, and CMD goes to ACK_CMD.
- ACK_CMD goes to CNT, and CNT goes to ACK_CNT.
- ACK_CNT goes to DATA.
- DATA goes to ACK_DATA while the byte count is not used up, or to SKIP once it is.
- ACK_DATA goes back to DATA.
- SKIP waits for the next start or stop.

Each ACK_* state is left on the SCL falling edge that ends the ninth clock.

Top module: `clkbuf_serial_ctrl`

## Requirements
- R1: After reset, every bit of `pair_en_o` is 1 and `pll_test_off_o` is 1. This holds until a data byte writes a register.
- R2: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Bytes clocked without a preceding start are not acknowledged and change nothing.
- R3: The slave acknowledges the address byte only when it equals the device address followed by a 0 direction bit. On any other address byte, including the device address with direction bit 1, `sda_oe_o` stays 0 and no register changes until the next start. `sda_oe_o` changes only just after an SCL falling edge.
- R4: After an accepted address, the next byte is taken as the command (the start register index) and the byte after it as the count. Both are acknowledged.
- R5: Data bytes are written to register index = command, command+1, and so on. The first "count" data bytes are acknowledged. Any data byte beyond the count is not acknowledged and is discarded. Outputs change only when a data byte is written.
- R6: A data byte aimed at an index above 2 is acknowledged but changes no output.
- R7: Register 0 maps to the pair enables as follows: bit 7 drives `pair_en_o[0]`, bit 6 drives `pair_en_o[1]`, bit 3 drives `pair_en_o[2]`, bit 2 drives `pair_en_o[5]` and bit 0 drives `pair_en_o[4]`. Bits 5, 4 and 1 of register 0 have no effect. A 1 enables a pair.
- R8: Register 1 bit 6 drives `pair_en_o[3]`. Register 2 bit 7 drives `pll_test_off_o`, where 0 selects the leakage test and 1 turns it off. All other bits of registers 1 and 2 have no effect.
- R9: A stop or repeated start in the middle of a transaction aborts it. Registers already written keep their values. After a repeated start, the slave decodes a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired value) |
| sda_oe_o | output | 1 | 1 pulls SDA low (acknowledge), 0 releases it |
| pair_en_o | output | NUM_PAIRS (6) | Enable per differential output pair, 1 = driven |
| pll_test_off_o | output | 1 | 0 selects the leakage test, 1 disables it |

## Verification
The bench aims at the header and counting corner cases. A count of zero must refuse the first data byte. A slave that ignored the count would accept and write it. A write that runs past index 2 must be acknowledged yet change nothing. A design that wrapped the index would corrupt register 0. Mid-transaction stops and repeated starts are checked to keep earlier writes and to re-decode the address. A design that cleared state on abort would lose the written pair enables. A design that kept the old byte position would misread the new address. The bench also checks that the reserved bits and the read direction bit are ignored. A loose address compare would acknowledge the read form or let reserved bits move an enable.

// File: rtl/sctl_pkg.sv
package sctl_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_REGS  = 3;
    localparam int NUM_PAIRS = 6;
    localparam logic [REG_W-1:0] LAST_IDX = REG_W'(NUM_REGS - 1);

    // implemented (non-reserved) bits of register 0
    localparam logic [REG_W-1:0] REG0_USED = 8'hCD;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_ADDR,
        ST_CMD,
        ST_ACK_CMD,
        ST_CNT,
        ST_ACK_CNT,
        ST_DATA,
        ST_ACK_DATA,
        ST_SKIP
    } sctl_state_e;

    // register index holding the enable of a pair
    function automatic int pair_reg(input int p);
        return (p == 3) ? 1 : 0;
    endfunction

    // bit position of the enable of a pair within its register
    function automatic int pair_bit(input int p);
        case (p)
            0:       return 7;
            1:       return 6;
            2:       return 3;
            3:       return 6;
            4:       return 0;
            default: return 2;
        endcase
    endfunction

    localparam int TEST_REG = 2;
    localparam int TEST_BIT = 7;

endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_s;
    logic              scl_p;
    logic              sda_p;

    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= scl_i;
                    sda_pipe <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_pipe <= '1;
                    sda_pipe <= '1;
                end else begin
                    scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
                    sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/sctl_fsm.sv
module sctl_fsm
    import sctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic             wr_en,
    output logic [REG_W-1:0] wr_idx,
    output logic [REG_W-1:0] wr_data
);

    localparam logic [REG_W-1:0] ADDR_WR = {DEV_ADDR, 1'b0};

    sctl_state_e      state_q, state_d;
    logic [REG_W-1:0] shreg_q;
    logic [3:0]       bitcnt_q;
    logic             rise_seen_q;
    logic [REG_W-1:0] idx_q;
    logic [REG_W-1:0] left_q;

    logic byte_done;
    logic byte_close;
    logic ack_end;
    logic in_rx;
    logic in_ack;

    assign byte_done  = (bitcnt_q == 4'd8);
    assign byte_close = scl_fall && byte_done;
    assign ack_end    = scl_fall && rise_seen_q;
    assign in_rx  = (state_q == ST_ADDR) || (state_q == ST_CMD) ||
                    (state_q == ST_CNT)  || (state_q == ST_DATA);
    assign in_ack = (state_q == ST_ACK_ADDR) || (state_q == ST_ACK_CMD) ||
                    (state_q == ST_ACK_CNT)  || (state_q == ST_ACK_DATA);

    // next state
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_close)
                                 state_d = (shreg_q == ADDR_WR) ? ST_ACK_ADDR : ST_SKIP;
                ST_ACK_ADDR: if (ack_end) state_d = ST_CMD;
                ST_CMD:      if (byte_close) state_d = ST_ACK_CMD;
                ST_ACK_CMD:  if (ack_end) state_d = ST_CNT;
                ST_CNT:      if (byte_close) state_d = ST_ACK_CNT;
                ST_ACK_CNT:  if (ack_end) state_d = ST_DATA;
                ST_DATA:     if (byte_close)
                                 state_d = (left_q != '0) ? ST_ACK_DATA : ST_SKIP;
                ST_ACK_DATA: if (ack_end) state_d = ST_DATA;
                ST_SKIP:     state_d = ST_SKIP;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // byte assembly, header capture and counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q     <= '0;
            bitcnt_q    <= '0;
            rise_seen_q <= 1'b0;
            idx_q       <= '0;
            left_q      <= '0;
        end else if (start_det) begin
            bitcnt_q    <= '0;
            rise_seen_q <= 1'b0;
        end else begin
            if (in_rx && scl_rise && !byte_done) begin
                shreg_q  <= {shreg_q[REG_W-2:0], sda_s};
                bitcnt_q <= bitcnt_q + 4'd1;
            end
            if (in_ack) begin
                if (scl_rise) rise_seen_q <= 1'b1;
                if (ack_end) begin
                    rise_seen_q <= 1'b0;
                    bitcnt_q    <= '0;
                end
            end
            if (byte_close) begin
                if (state_q == ST_CMD) idx_q <= shreg_q;
                if (state_q == ST_CNT) left_q <= shreg_q;
                if (state_q == ST_DATA && left_q != '0) begin
                    left_q <= left_q - 1'b1;
                    if (idx_q != '1) idx_q <= idx_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        sda_oe  = in_ack;
        wr_en   = (state_q == ST_DATA) && byte_close && (left_q != '0) && (idx_q <= LAST_IDX);
        wr_idx  = idx_q;
        wr_data = shreg_q;
    end

    // R2: a start always restarts address decoding from the first bit
    assert_start_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR) && (bitcnt_q == 4'd0));

    // R3: the data line is only grabbed or released right after SCL falls
    assert_oe_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> $past(scl_fall));

    // R9: a stop leaves the line released and performs no write
    assert_stop_aborts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe && !wr_en);

endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_idx,
    input  logic [REG_W-1:0]     wr_data,
    output logic [NUM_PAIRS-1:0] pair_en_o,
    output logic                 test_off_o
);

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            localparam logic [REG_W-1:0] OWNER = REG_W'(pair_reg(p));
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    pair_en_o[p] <= 1'b1;
                else if (wr_en && wr_idx == OWNER)
                    pair_en_o[p] <= wr_data[pair_bit(p)];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            test_off_o <= 1'b1;
        else if (wr_en && wr_idx == REG_W'(TEST_REG))
            test_off_o <= wr_data[TEST_BIT];
    end

    // R5: outputs hold whenever no write is presented
    assert_hold_without_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(pair_en_o) && $stable(test_off_o));

    // R6: the writer never presents an index beyond the last register
    assert_index_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx <= LAST_IDX);

    // R7: reserved bits of register 0 cannot turn any pair on
    assert_reserved_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == '0 && (wr_data & REG0_USED) == '0)
        |=> !pair_en_o[0] && !pair_en_o[1] && !pair_en_o[2] && !pair_en_o[4] && !pair_en_o[5]);

endmodule

// File: rtl/clkbuf_serial_ctrl.sv
module clkbuf_serial_ctrl
    import sctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    output logic [NUM_PAIRS-1:0] pair_en_o,
    output logic                 pll_test_off_o
);

    logic             sda_s;
    logic             scl_rise;
    logic             scl_fall;
    logic             start_det;
    logic             stop_det;
    logic             wr_en;
    logic [REG_W-1:0] wr_idx;
    logic [REG_W-1:0] wr_data;

    sctl_sync #(
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    sctl_fsm #(
        .DEV_ADDR(DEV_ADDR)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .sda_oe   (sda_oe_o),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_data  (wr_data)
    );

    sctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .pair_en_o (pair_en_o),
        .test_off_o(pll_test_off_o)
    );

endmodule

// File: tb/clkbuf_serial_ctrl_tb.sv
module clkbuf_serial_ctrl_tb;

    localparam int         CLK_PERIOD = 10;
    localparam int         Q          = 6;
    localparam logic [6:0] DEV        = 7'h69;

    typedef struct packed {
        logic [7:0] cmd;
        logic [7:0] cnt;
        logic [7:0] d0;
        logic [7:0] d1;
        logic [7:0] d2;
        logic [5:0] pairs;
        logic       tst;
    } vec_t;

    // cumulative: each row starts from the state left by the previous one
    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{8'd0, 8'd1, 8'h00, 8'h00, 8'h00, 6'b001000, 1'b1},
        '{8'd0, 8'd1, 8'h80, 8'h00, 8'h00, 6'b001001, 1'b1},
        '{8'd0, 8'd3, 8'h4C, 8'h00, 8'h00, 6'b100110, 1'b0},
        '{8'd1, 8'd2, 8'h40, 8'h80, 8'h00, 6'b101110, 1'b1},
        '{8'd2, 8'd1, 8'h7F, 8'h00, 8'h00, 6'b101110, 1'b0},
        '{8'd0, 8'd2, 8'h01, 8'hBF, 8'h00, 6'b010000, 1'b0},
        '{8'd3, 8'd1, 8'h00, 8'h00, 8'h00, 6'b010000, 1'b0},
        '{8'd2, 8'd2, 8'hFF, 8'h00, 8'h00, 6'b010000, 1'b1},
        '{8'd0, 8'd1, 8'h32, 8'h00, 8'h00, 6'b000000, 1'b1},
        '{8'd0, 8'd3, 8'hFF, 8'hFF, 8'hFF, 6'b111111, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [5:0] pair_en;
    logic       test_off;

    int n_chk = 0;
    int n_fail = 0;
    int oe_cycles = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus = sda_m & ~sda_oe;

    always @(posedge clk) if (sda_oe) oe_cycles <= oe_cycles + 1;

    clkbuf_serial_ctrl #(.DEV_ADDR(DEV), .SYNC_STAGES(2)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_i         (scl),
        .sda_i         (sda_bus),
        .sda_oe_o      (sda_oe),
        .pair_en_o     (pair_en),
        .pll_test_off_o(test_off)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(posedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b0;   wait_clk(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_clk(Q);
        scl = 1'b1;   wait_clk(Q);
        sda_m = 1'b1; wait_clk(4 * Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            wait_clk(Q);
            sda_m = b[i];
            wait_clk(Q);
            scl = 1'b1;
            wait_clk(2 * Q);
            scl = 1'b0;
        end
        wait_clk(Q);
        sda_m = 1'b1;
        wait_clk(Q);
        scl = 1'b1;
        wait_clk(Q);
        @(negedge clk);
        ack = ~sda_bus;
        wait_clk(Q);
        scl = 1'b0;
    endtask

    // start, address, command, count, n data bytes, optional stop
    task automatic xfer(input logic [7:0] cmd, input logic [7:0] cnt,
                        input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                        input int n, input bit stop, output logic [5:0] acks);
        logic a;
        acks = '0;
        bus_start();
        send_byte({DEV, 1'b0}, a); acks[0] = a;
        send_byte(cmd, a);         acks[1] = a;
        send_byte(cnt, a);         acks[2] = a;
        if (n > 0) begin send_byte(d0, a); acks[3] = a; end
        if (n > 1) begin send_byte(d1, a); acks[4] = a; end
        if (n > 2) begin send_byte(d2, a); acks[5] = a; end
        if (stop) bus_stop();
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        scl = 1'b1;
        sda_m = 1'b1;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(5);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [5:0] acks;
        logic       a;
        int         oe0;

        do_reset();
        @(negedge clk);
        chk("R1 reset pairs", 32'(pair_en), 32'h3F);
        chk("R1 reset test bit", 32'(test_off), 32'h1);
        chk("R3 line released after reset", 32'(sda_oe), 32'h0);

        // vector table: R4 R5 R6 R7 R8
        for (int v = 0; v < NV; v++) begin
            xfer(VECS[v].cmd, VECS[v].cnt, VECS[v].d0, VECS[v].d1, VECS[v].d2,
                 int'(VECS[v].cnt), 1'b1, acks);
            @(negedge clk);
            chk($sformatf("R4 header acks vec %0d", v), 32'(acks[2:0]), 32'h7);
            chk($sformatf("R5 R6 data acks vec %0d", v), 32'(acks[5:3]),
                32'((6'b000111 >> (3 - int'(VECS[v].cnt))) & 3'b111));
            chk($sformatf("R7 R8 pairs vec %0d", v), 32'(pair_en), 32'(VECS[v].pairs));
            chk($sformatf("R8 test bit vec %0d", v), 32'(test_off), 32'(VECS[v].tst));
        end

        // R3: foreign address ignored, bus never driven
        oe0 = oe_cycles;
        bus_start();
        send_byte({7'h2A, 1'b0}, a);
        chk("R3 foreign address nack", 32'(a), 32'h0);
        send_byte(8'h00, a);
        send_byte(8'h01, a);
        send_byte(8'h00, a);
        bus_stop();
        @(negedge clk);
        chk("R3 foreign address no drive", 32'(oe_cycles - oe0), 32'h0);
        chk("R3 foreign address no write", 32'(pair_en), 32'h3F);

        // R3: read direction bit not accepted
        bus_start();
        send_byte({DEV, 1'b1}, a);
        chk("R3 read direction nack", 32'(a), 32'h0);
        bus_stop();

        // R2: bytes without a start are ignored
        send_byte({DEV, 1'b0}, a);
        chk("R2 no start nack", 32'(a), 32'h0);
        send_byte(8'h00, a);
        bus_stop();
        @(negedge clk);
        chk("R2 no start no write", 32'(pair_en), 32'h3F);

        // R5: count of zero refuses data
        xfer(8'd1, 8'd0, 8'h00, 8'h00, 8'h00, 1, 1'b1, acks);
        @(negedge clk);
        chk("R5 beyond count nack", 32'(acks[3]), 32'h0);
        chk("R5 beyond count discarded", 32'(pair_en), 32'h3F);

        // R9: stop aborts, earlier write kept
        xfer(8'd0, 8'd3, 8'h00, 8'h00, 8'h00, 1, 1'b1, acks);
        @(negedge clk);
        chk("R9 stop keeps written reg0", 32'(pair_en), 32'h08);
        chk("R9 stop leaves reg2", 32'(test_off), 32'h1);
        xfer(8'd2, 8'd1, 8'h00, 8'h00, 8'h00, 1, 1'b1, acks);
        @(negedge clk);
        chk("R9 fresh write after abort", 32'(test_off), 32'h0);

        // R9 R2: repeated start mid-header, address decoded afresh
        xfer(8'd1, 8'd1, 8'h00, 8'h00, 8'h00, 0, 1'b0, acks);
        xfer(8'd0, 8'd1, 8'h80, 8'h00, 8'h00, 1, 1'b1, acks);
        @(negedge clk);
        chk("R9 repeated start acks", 32'(acks[3:0]), 32'hF);
        chk("R9 repeated start pairs", 32'(pair_en), 32'h09);

        // R1: reset in mid transaction restores power-up values
        xfer(8'd0, 8'd1, 8'h00, 8'h00, 8'h00, 0, 1'b0, acks);
        do_reset();
        @(negedge clk);
        chk("R1 reset mid transfer pairs", 32'(pair_en), 32'h3F);
        chk("R1 reset mid transfer test", 32'(test_off), 32'h1);
        chk("R1 reset mid transfer line", 32'(sda_oe), 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule